// File: doc/BRIEF.md
# Outbound Address Translation Window Bank

This block holds a small bank of programmable windows that carry addresses from a local on-chip bus into a 64-bit remote address space on the far side of a serial link. Every window has four words at a fixed 16-byte stride: a control word, a local base, a remote address low word and a remote address high word. Each window also has one extended size word in a separate area, with a 4-byte stride. A control word holds an enable bit and a 2-bit kind field. Its upper bits carry the low half of the window's size mask, written as the bitwise inverse of (size - 1). The extended word carries the upper 32 bits of that mask.

A lookup presents a 32-bit local address. The result comes out one cycle later. It gives the index and kind of the winning window and the translated 64-bit remote address, or a miss. Configuration-kind windows do not use the mask. They build the remote address from the bus, device and function numbers held in the remote low word, and they report those numbers on separate outputs. Software programs and reads back all words through a plain CSR port. Its writes take effect at the clock edge and its reads are combinational.

Top module: `obw_xlate`

## Requirements
- R1: After reset every register reads 0, no window is enabled, and the outputs res_valid, res_hit and res_miss are 0.
- R2: CSR byte map. Window n's words are at n*16: +0x0 control, +0x4 local base, +0x8 remote low, +0xC remote high. Window n's extended size word is at 0x80 + n*4. Address bits 1:0 are ignored. Writes read back unchanged. An unmapped address (0xA0 and up) reads 0, and a write to it changes no register.
- R3: In the control word, bit 0 is the enable and bits 2:1 are the kind: 0 configuration, 1 I/O, 2 memory, 3 treated like memory. Bits 31:12 form the low mask, and mask bits 11:0 are always 0, which gives a 4 KiB granularity.
- R4: The local base word always reads back with bits 1:0 cleared.
- R5: A lookup address hits window n when n is enabled and (addr AND mask) equals (base AND mask), where mask = {control[31:12], 12'h000}.
- R6: A hit on a window of kind other than configuration yields res_addr = (remote64 AND M) OR (zero-extended addr AND NOT M), where M = {extended word, mask} and remote64 = {remote high, remote low}.
- R7: A hit on a configuration-kind window yields res_addr = {32'h0, remote_low[31:16], addr[15:0]}. It also yields res_bus = remote_low[31:24], res_dev = remote_low[23:19] and res_fn = remote_low[18:16]. For any other result the bus, device and function outputs are 0.
- R8: When several windows hit, the lowest-numbered one wins. Its index appears on res_win and its kind on res_type.
- R9: When no window hits, res_miss is 1, res_hit is 0, and res_addr, res_win and res_type are 0.
- R10: res_valid is 1 exactly one cycle after lk_valid was 1 and 0 otherwise. Exactly one of res_hit and res_miss is set when res_valid is 1, and neither is set when it is 0.
- R11: A lookup issued in the same cycle as a CSR write is judged against the register contents from before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| csr_we | input | 1 | CSR write strobe |
| csr_addr | input | CSR_AW (8) | CSR byte address |
| csr_wdata | input | 32 | CSR write data |
| csr_rdata | output | 32 | CSR read data for csr_addr, combinational |
| lk_valid | input | 1 | Lookup request |
| lk_addr | input | 32 | Local address to translate |
| res_valid | output | 1 | Lookup result present |
| res_hit | output | 1 | A window matched |
| res_miss | output | 1 | No window matched |
| res_win | output | WIN_IW (3) | Index of the winning window |
| res_type | output | 2 | Kind of the winning window |
| res_addr | output | 64 | Translated remote address |
| res_bus | output | 8 | Bus number for a configuration hit |
| res_dev | output | 5 | Device number for a configuration hit |
| res_fn | output | 3 | Function number for a configuration hit |

## Verification
A CSR write and a lookup can land in the same cycle. The question is then whether the lookup sees the window as it was or as it is being rewritten. The bench provokes this case in two ways. In one, a lookup that targets a live window is issued while its control word is rewritten to disable it. In the other, a lookup is issued while a disabled window is being enabled. In both cases the expected result comes from the bench's own register model before that write is applied, and the following lookup is checked against the updated model.

// File: rtl/obw_pkg.sv
package obw_pkg;

  localparam int LOC_W = 32;
  localparam int REM_W = 64;

  typedef enum logic [1:0] {
    WK_CFG  = 2'd0,
    WK_IO   = 2'd1,
    WK_MEM  = 2'd2,
    WK_RSVD = 2'd3
  } win_kind_e;

  // control word with everything below the granule cleared
  function automatic logic [31:0] gran_mask(input logic [31:0] ctrl, input int unsigned lg2);
    logic [31:0] keep;
    keep = 32'hFFFF_FFFF << lg2;
    return ctrl & keep;
  endfunction

  function automatic logic window_hits(input logic [31:0] ctrl, input logic [31:0] base,
                                       input logic [LOC_W-1:0] addr, input int unsigned lg2);
    logic [31:0] m;
    m = gran_mask(ctrl, lg2);
    return ctrl[0] && ((addr & m) == (base & m));
  endfunction

  function automatic logic [REM_W-1:0] remap(input logic [REM_W-1:0] rem,
                                             input logic [REM_W-1:0] mask64,
                                             input logic [LOC_W-1:0] addr);
    logic [REM_W-1:0] wide;
    wide = {{(REM_W-LOC_W){1'b0}}, addr};
    return (rem & mask64) | (wide & ~mask64);
  endfunction

  function automatic logic [REM_W-1:0] cfg_target(input logic [31:0] rlo,
                                                  input logic [LOC_W-1:0] addr);
    return {32'h0, rlo[31:16], addr[15:0]};
  endfunction

endpackage

// File: rtl/obw_regfile.sv
module obw_regfile #(
  parameter int NUM_WIN = 8,
  parameter int CSR_AW  = 8,
  parameter int WIN_IW  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [CSR_AW-1:0] addr,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata,
  output logic [31:0]       ctrl_o [NUM_WIN],
  output logic [31:0]       base_o [NUM_WIN],
  output logic [31:0]       rlo_o  [NUM_WIN],
  output logic [31:0]       rhi_o  [NUM_WIN],
  output logic [31:0]       ext_o  [NUM_WIN]
);

  localparam int GRP_STRIDE = 16;
  localparam int EXT_STRIDE = 4;
  localparam logic [CSR_AW:0] GRP_END  = (CSR_AW+1)'(NUM_WIN * GRP_STRIDE);
  localparam logic [CSR_AW:0] EXT_BASE = GRP_END;
  localparam logic [CSR_AW:0] EXT_END  = (CSR_AW+1)'(NUM_WIN * (GRP_STRIDE + EXT_STRIDE));

  logic              grp_sel, ext_sel;
  logic [WIN_IW-1:0] grp_idx, ext_idx;
  logic [1:0]        word_sel;
  logic [CSR_AW:0]   ext_off;

  always_comb begin
    grp_sel  = {1'b0, addr} < GRP_END;
    ext_sel  = ({1'b0, addr} >= EXT_BASE) && ({1'b0, addr} < EXT_END);
    grp_idx  = addr[4 +: WIN_IW];
    word_sel = addr[3:2];
    ext_off  = {1'b0, addr} - EXT_BASE;
    ext_idx  = ext_off[2 +: WIN_IW];
  end

  for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
    logic grp_wr, ext_wr;
    assign grp_wr = we && grp_sel && (grp_idx == WIN_IW'(w));
    assign ext_wr = we && ext_sel && (ext_idx == WIN_IW'(w));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ctrl_o[w] <= '0;
        base_o[w] <= '0;
        rlo_o[w]  <= '0;
        rhi_o[w]  <= '0;
      end else if (grp_wr) begin
        case (word_sel)
          2'd0:    ctrl_o[w] <= wdata;
          2'd1:    base_o[w] <= {wdata[31:2], 2'b00};
          2'd2:    rlo_o[w]  <= wdata;
          default: rhi_o[w]  <= wdata;
        endcase
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      ext_o[w] <= '0;
      else if (ext_wr) ext_o[w] <= wdata;
    end

    // R4: a base word never holds the two low bits
    a_r4_base_aligned: assert property (@(posedge clk) disable iff (!rst_n)
      (grp_wr && word_sel == 2'd1) |=> (base_o[w][1:0] == 2'b00));
  end

  always_comb begin
    rdata = '0;
    if (grp_sel) begin
      case (word_sel)
        2'd0:    rdata = ctrl_o[grp_idx];
        2'd1:    rdata = base_o[grp_idx];
        2'd2:    rdata = rlo_o[grp_idx];
        default: rdata = rhi_o[grp_idx];
      endcase
    end else if (ext_sel) begin
      rdata = ext_o[ext_idx];
    end
  end

endmodule

// File: rtl/obw_match.sv
module obw_match
  import obw_pkg::*;
#(
  parameter int NUM_WIN  = 8,
  parameter int GRAN_LG2 = 12
) (
  input  logic [31:0]      ctrl_i [NUM_WIN],
  input  logic [31:0]      base_i [NUM_WIN],
  input  logic [LOC_W-1:0] addr,
  output logic [NUM_WIN-1:0] hit_vec
);

  for (genvar w = 0; w < NUM_WIN; w++) begin : g_cmp
    assign hit_vec[w] = window_hits(ctrl_i[w], base_i[w], addr, GRAN_LG2);
  end

endmodule

// File: rtl/obw_select.sv
module obw_select
  import obw_pkg::*;
#(
  parameter int NUM_WIN  = 8,
  parameter int GRAN_LG2 = 12,
  parameter int WIN_IW   = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               lk_valid,
  input  logic [LOC_W-1:0]   lk_addr,
  input  logic [NUM_WIN-1:0] hit_vec,
  input  logic [31:0]        ctrl_i [NUM_WIN],
  input  logic [31:0]        rlo_i  [NUM_WIN],
  input  logic [31:0]        rhi_i  [NUM_WIN],
  input  logic [31:0]        ext_i  [NUM_WIN],
  output logic               res_valid,
  output logic               res_hit,
  output logic               res_miss,
  output logic [WIN_IW-1:0]  res_win,
  output logic [1:0]         res_type,
  output logic [REM_W-1:0]   res_addr,
  output logic [7:0]         res_bus,
  output logic [4:0]         res_dev,
  output logic [2:0]         res_fn
);

  logic [NUM_WIN-1:0] grant;
  logic [WIN_IW-1:0]  win_idx;
  logic               found;
  logic [31:0]        sel_ctrl, sel_rlo;
  logic [REM_W-1:0]   sel_mask, sel_rem, xl_addr;
  win_kind_e          sel_kind;
  logic               is_cfg;

  always_comb begin
    grant   = '0;
    win_idx = '0;
    found   = 1'b0;
    for (int i = 0; i < NUM_WIN; i++) begin
      if (hit_vec[i] && !found) begin
        found    = 1'b1;
        grant[i] = 1'b1;
        win_idx  = WIN_IW'(i);
      end
    end
  end

  always_comb begin
    sel_ctrl = ctrl_i[win_idx];
    sel_rlo  = rlo_i[win_idx];
    sel_kind = win_kind_e'(sel_ctrl[2:1]);
    sel_mask = {ext_i[win_idx], gran_mask(sel_ctrl, GRAN_LG2)};
    sel_rem  = {rhi_i[win_idx], sel_rlo};
    is_cfg   = (sel_kind == WK_CFG);
    xl_addr  = is_cfg ? cfg_target(sel_rlo, lk_addr) : remap(sel_rem, sel_mask, lk_addr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res_hit   <= 1'b0;
      res_miss  <= 1'b0;
      res_win   <= '0;
      res_type  <= '0;
      res_addr  <= '0;
      res_bus   <= '0;
      res_dev   <= '0;
      res_fn    <= '0;
    end else begin
      res_valid <= lk_valid;
      res_hit   <= lk_valid && found;
      res_miss  <= lk_valid && !found;
      if (lk_valid && found) begin
        res_win  <= win_idx;
        res_type <= sel_kind;
        res_addr <= xl_addr;
        res_bus  <= is_cfg ? sel_rlo[31:24] : 8'h0;
        res_dev  <= is_cfg ? sel_rlo[23:19] : 5'h0;
        res_fn   <= is_cfg ? sel_rlo[18:16] : 3'h0;
      end else begin
        res_win  <= '0;
        res_type <= '0;
        res_addr <= '0;
        res_bus  <= '0;
        res_dev  <= '0;
        res_fn   <= '0;
      end
    end
  end

  // R8: exactly one grant, on a hitting window with no lower hit
  a_r8_lowest_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (|hit_vec) |-> (($countones(grant) == 1) && ((grant & hit_vec) == grant)
                    && (((grant - 1'b1) & hit_vec) == '0)));

  // R9: no grant without a hit
  a_r9_no_grant: assert property (@(posedge clk) disable iff (!rst_n)
    !(|hit_vec) |-> (grant == '0));

  // R10: result follows the request by one cycle
  a_r10_valid_next: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid |=> res_valid);
  a_r10_idle_next: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_valid |=> !res_valid);
  a_r10_hit_xor_miss: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> (res_hit != res_miss));
  a_r10_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !res_valid |-> (!res_hit && !res_miss));

  // R9: a miss carries a zero address and kind
  a_r9_miss_zero: assert property (@(posedge clk) disable iff (!rst_n)
    res_miss |-> (res_addr == '0 && res_type == 2'd0 && res_win == '0));

  // R7: configuration results stay in the lower 4 GiB
  a_r7_cfg_low: assert property (@(posedge clk) disable iff (!rst_n)
    (res_hit && res_type == 2'd0) |-> (res_addr[63:32] == 32'h0));

endmodule

// File: rtl/obw_xlate.sv
module obw_xlate
  import obw_pkg::*;
#(
  parameter int NUM_WIN  = 8,
  parameter int CSR_AW   = 8,
  parameter int GRAN_LG2 = 12,
  localparam int WIN_IW  = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              csr_we,
  input  logic [CSR_AW-1:0] csr_addr,
  input  logic [31:0]       csr_wdata,
  output logic [31:0]       csr_rdata,
  input  logic              lk_valid,
  input  logic [31:0]       lk_addr,
  output logic              res_valid,
  output logic              res_hit,
  output logic              res_miss,
  output logic [WIN_IW-1:0] res_win,
  output logic [1:0]        res_type,
  output logic [63:0]       res_addr,
  output logic [7:0]        res_bus,
  output logic [4:0]        res_dev,
  output logic [2:0]        res_fn
);

  logic [31:0]        ctrl_w [NUM_WIN];
  logic [31:0]        base_w [NUM_WIN];
  logic [31:0]        rlo_w  [NUM_WIN];
  logic [31:0]        rhi_w  [NUM_WIN];
  logic [31:0]        ext_w  [NUM_WIN];
  logic [NUM_WIN-1:0] hit_vec;

  obw_regfile #(.NUM_WIN(NUM_WIN), .CSR_AW(CSR_AW), .WIN_IW(WIN_IW)) regs_i (
    .clk(clk), .rst_n(rst_n), .we(csr_we), .addr(csr_addr), .wdata(csr_wdata),
    .rdata(csr_rdata), .ctrl_o(ctrl_w), .base_o(base_w), .rlo_o(rlo_w),
    .rhi_o(rhi_w), .ext_o(ext_w)
  );

  obw_match #(.NUM_WIN(NUM_WIN), .GRAN_LG2(GRAN_LG2)) match_i (
    .ctrl_i(ctrl_w), .base_i(base_w), .addr(lk_addr), .hit_vec(hit_vec)
  );

  obw_select #(.NUM_WIN(NUM_WIN), .GRAN_LG2(GRAN_LG2), .WIN_IW(WIN_IW)) sel_i (
    .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_addr(lk_addr),
    .hit_vec(hit_vec), .ctrl_i(ctrl_w), .rlo_i(rlo_w), .rhi_i(rhi_w), .ext_i(ext_w),
    .res_valid(res_valid), .res_hit(res_hit), .res_miss(res_miss), .res_win(res_win),
    .res_type(res_type), .res_addr(res_addr), .res_bus(res_bus), .res_dev(res_dev),
    .res_fn(res_fn)
  );

endmodule

// File: tb/obw_xlate_tb_top.sv
`timescale 1ns/1ps
module obw_xlate_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        csr_we = 1'b0;
  logic [7:0]  csr_addr = '0;
  logic [31:0] csr_wdata = '0;
  logic [31:0] csr_rdata;
  logic        lk_valid = 1'b0;
  logic [31:0] lk_addr = '0;
  logic        res_valid, res_hit, res_miss;
  logic [2:0]  res_win;
  logic [1:0]  res_type;
  logic [63:0] res_addr;
  logic [7:0]  res_bus;
  logic [4:0]  res_dev;
  logic [2:0]  res_fn;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  obw_xlate dut_i (
    .clk(clk), .rst_n(rst_n), .csr_we(csr_we), .csr_addr(csr_addr),
    .csr_wdata(csr_wdata), .csr_rdata(csr_rdata), .lk_valid(lk_valid),
    .lk_addr(lk_addr), .res_valid(res_valid), .res_hit(res_hit), .res_miss(res_miss),
    .res_win(res_win), .res_type(res_type), .res_addr(res_addr), .res_bus(res_bus),
    .res_dev(res_dev), .res_fn(res_fn)
  );

  // bench register model
  logic [31:0] m_ctrl [8];
  logic [31:0] m_base [8];
  logic [31:0] m_rlo  [8];
  logic [31:0] m_rhi  [8];
  logic [31:0] m_ext  [8];

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic model_write(input logic [7:0] a, input logic [31:0] d);
    int idx;
    if (a < 8'h80) begin
      idx = int'(a) / 16;
      case ((int'(a) % 16) / 4)
        0: m_ctrl[idx] = d;
        1: m_base[idx] = d & 32'hFFFF_FFFC;
        2: m_rlo[idx]  = d;
        default: m_rhi[idx] = d;
      endcase
    end else if (a < 8'hA0) begin
      m_ext[(int'(a) - 128) / 4] = d;
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    csr_we = 1'b1; csr_addr = a; csr_wdata = d;
    @(negedge clk);
    csr_we = 1'b0;
    model_write(a, d);
  endtask

  task automatic rd_chk(input string req, input logic [7:0] a, input logic [31:0] exp);
    @(negedge clk);
    csr_addr = a;
    #1;
    chk(req, {32'h0, csr_rdata}, {32'h0, exp});
  endtask

  // expected lookup outcome, written from the requirements
  task automatic expect_lk(input logic [31:0] a, output logic hit, output logic [2:0] win,
                           output logic [1:0] typ, output logic [63:0] ea,
                           output logic [7:0] bus, output logic [4:0] dev, output logic [2:0] fn);
    hit = 0; win = 0; typ = 0; ea = 0; bus = 0; dev = 0; fn = 0;
    for (int i = 7; i >= 0; i--) begin
      logic [31:0] m;
      logic [63:0] mm, rem;
      m = (m_ctrl[i] >> 12) << 12;
      if (m_ctrl[i][0] && (((a ^ m_base[i]) & m) == 32'h0)) begin
        hit = 1; win = 3'(i); typ = m_ctrl[i][2:1];
        mm  = {m_ext[i], m};
        rem = {m_rhi[i], m_rlo[i]};
        if (typ == 2'd0) begin
          ea  = {32'h0, m_rlo[i][31:16], a[15:0]};
          bus = m_rlo[i][31:24]; dev = m_rlo[i][23:19]; fn = m_rlo[i][18:16];
        end else begin
          ea  = rem ^ ((rem ^ {32'h0, a}) & ~mm);
          bus = 0; dev = 0; fn = 0;
        end
      end
    end
  endtask

  task automatic compare_result(input string req, input logic hit, input logic [2:0] win,
                                input logic [1:0] typ, input logic [63:0] ea,
                                input logic [7:0] bus, input logic [4:0] dev, input logic [2:0] fn);
    chk({req, "/R10 valid"}, {63'h0, res_valid}, 64'h1);
    chk({req, "/R10 hit"},   {63'h0, res_hit},   {63'h0, hit});
    chk({req, "/R9 miss"},   {63'h0, res_miss},  {63'h0, !hit});
    chk({req, "/R8 win"},    {61'h0, res_win},   {61'h0, win});
    chk({req, "/R8 type"},   {62'h0, res_type},  {62'h0, typ});
    chk({req, "/R6 addr"},   res_addr, ea);
    chk({req, "/R7 bdf"},    {48'h0, res_bus, res_dev, res_fn}, {48'h0, bus, dev, fn});
  endtask

  task automatic look(input string req, input logic [31:0] a);
    logic hit; logic [2:0] win; logic [1:0] typ; logic [63:0] ea;
    logic [7:0] bus; logic [4:0] dev; logic [2:0] fn;
    @(negedge clk);
    lk_valid = 1'b1; lk_addr = a;
    expect_lk(a, hit, win, typ, ea, bus, dev, fn);
    @(negedge clk);
    lk_valid = 1'b0;
    compare_result(req, hit, win, typ, ea, bus, dev, fn);
  endtask

  // R11: write and lookup in one cycle
  task automatic look_during_write(input string req, input logic [31:0] a,
                                   input logic [7:0] wa, input logic [31:0] wd);
    logic hit; logic [2:0] win; logic [1:0] typ; logic [63:0] ea;
    logic [7:0] bus; logic [4:0] dev; logic [2:0] fn;
    @(negedge clk);
    expect_lk(a, hit, win, typ, ea, bus, dev, fn);
    lk_valid = 1'b1; lk_addr = a;
    csr_we = 1'b1; csr_addr = wa; csr_wdata = wd;
    @(negedge clk);
    lk_valid = 1'b0; csr_we = 1'b0;
    model_write(wa, wd);
    compare_result(req, hit, win, typ, ea, bus, dev, fn);
  endtask

  task automatic prog(input int w, input logic en, input logic [1:0] typ, input int lg2,
                      input logic [31:0] base, input logic [63:0] rem, input logic [31:0] ext);
    logic [31:0] sz;
    sz = 32'd1 << lg2;
    wr(8'(w * 16),      (~(sz - 32'd1) & 32'hFFFF_F000) | {29'h0, typ, en});
    wr(8'(w * 16 + 4),  base);
    wr(8'(w * 16 + 8),  rem[31:0]);
    wr(8'(w * 16 + 12), rem[63:32]);
    wr(8'(128 + w * 4), ext);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : main
    int unsigned seed;
    seed = 32'd20240611;
    void'($urandom(seed));
    for (int i = 0; i < 8; i++) begin
      m_ctrl[i] = 0; m_base[i] = 0; m_rlo[i] = 0; m_rhi[i] = 0; m_ext[i] = 0;
    end
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 res_valid", {63'h0, res_valid}, 64'h0);
    chk("R1 hit/miss", {62'h0, res_hit, res_miss}, 64'h0);
    rst_n = 1'b1;
    for (int a = 0; a < 160; a += 4) rd_chk("R1 reset readback", 8'(a), 32'h0);
    look("R1 nothing enabled", 32'h1234_5678);

    // R2 readback of every word, R4 base alignment
    for (int w = 0; w < 8; w++) begin
      for (int k = 0; k < 4; k++) wr(8'(w * 16 + k * 4), $urandom());
      wr(8'(128 + w * 4), $urandom());
    end
    for (int a = 0; a < 160; a += 4) begin
      logic [31:0] e;
      e = (a < 128) ? ((a % 16) == 0 ? m_ctrl[a/16] : (a % 16) == 4 ? m_base[a/16] :
                       (a % 16) == 8 ? m_rlo[a/16] : m_rhi[a/16]) : m_ext[(a-128)/4];
      rd_chk("R2 readback", 8'(a), e);
    end
    wr(8'h14, 32'hABCD_EF13);
    rd_chk("R4 base low bits", 8'h14, 32'hABCD_EF10);
    rd_chk("R2 byte bits ignored", 8'h17, 32'hABCD_EF10);
    wr(8'hA0, 32'hFFFF_FFFF);
    wr(8'hFC, 32'h5555_5555);
    rd_chk("R2 unmapped read", 8'hA0, 32'h0);
    rd_chk("R2 unmapped read", 8'hFC, 32'h0);
    for (int a = 0; a < 160; a += 4) begin
      logic [31:0] e;
      e = (a < 128) ? ((a % 16) == 0 ? m_ctrl[a/16] : (a % 16) == 4 ? m_base[a/16] :
                       (a % 16) == 8 ? m_rlo[a/16] : m_rhi[a/16]) : m_ext[(a-128)/4];
      rd_chk("R2 unmapped write no effect", 8'(a), e);
    end

    // clear all windows
    for (int w = 0; w < 8; w++) prog(w, 1'b0, 2'd0, 12, 0, 0, 0);

    // R3/R5/R6 memory window, 1 MiB
    prog(0, 1'b1, 2'd2, 20, 32'h4010_0000, 64'h0000_0081_2340_0000, 32'hFFFF_FFFF);
    look("R6 memory hit", 32'h401A_BCDC);
    look("R5 just below", 32'h400F_FFFC);
    look("R5 just above", 32'h4020_0000);
    // R3 kind I/O and reserved kind
    prog(1, 1'b1, 2'd1, 12, 32'h0000_3000, 64'hDEAD_0000_0001_0000, 32'hFFFF_FFFF);
    look("R3 io kind", 32'h0000_3ABC);
    prog(2, 1'b1, 2'd3, 16, 32'h7777_0000, 64'h1_0000_0000, 32'hFFFF_FFFF);
    look("R3 reserved kind", 32'h7777_1234);
    // R6 upper mask zero carries no remote high bits
    prog(3, 1'b1, 2'd2, 24, 32'h9900_0000, 64'hFFFF_FFFF_AB00_0000, 32'h0000_0000);
    look("R6 ext mask zero", 32'h9912_3456);
    // R7 configuration window
    prog(4, 1'b1, 2'd0, 16, 32'hC000_0000, {32'h7, 8'h3A, 5'h15, 3'h6, 16'h0}, 32'hFFFF_FFFF);
    look("R7 config", 32'hC000_0ABC);
    // R8 overlap: windows 5 and 6 same region, and 0 enclosed later
    prog(6, 1'b1, 2'd2, 16, 32'h5000_0000, 64'h6_0000_0000, 32'hFFFF_FFFF);
    prog(5, 1'b1, 2'd1, 20, 32'h5000_0000, 64'h5_0000_0000, 32'hFFFF_FFFF);
    look("R8 lowest of overlap", 32'h5000_1234);
    look("R8 only larger", 32'h5008_0000);
    // R9 miss
    look("R9 miss", 32'hEEEE_0000);
    // R10 idle cycles
    @(negedge clk);
    @(negedge clk);
    chk("R10 idle no valid", {61'h0, res_valid, res_hit, res_miss}, 64'h0);
    // R11 disable window 0 while looking it up
    look_during_write("R11 old enabled", 32'h4010_0040, 8'h00, 32'h0);
    look("R11 now disabled", 32'h4010_0040);
    look_during_write("R11 old disabled", 32'h4010_0040, 8'h00, 32'hFFF0_0005);
    look("R11 now enabled", 32'h4010_0040);

    // random windows and lookups
    for (int w = 0; w < 8; w++) begin
      int lg2;
      lg2 = 12 + int'($urandom() % 17);
      prog(w, 1'($urandom()), 2'($urandom()), lg2, $urandom() & 32'hFFFF_FFFC,
           {$urandom(), $urandom()}, ($urandom() % 4 == 0) ? 32'h0 : 32'hFFFF_FFFF);
    end
    for (int n = 0; n < 300; n++) begin
      logic [31:0] a;
      int w;
      w = int'($urandom() % 8);
      if ($urandom() % 3 != 0) begin
        logic [31:0] m;
        m = (m_ctrl[w] >> 12) << 12;
        a = (m_base[w] & m) | ($urandom() & ~m);
      end else begin
        a = $urandom();
      end
      if (n % 50 == 7) look_during_write("R11 random", a, 8'(w * 16), $urandom());
      else look("R5 random", a);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule